// File: doc/BRIEF.md
# Successive-Approximation Code Pre-Distorter

This block turns an ideal binary code into the switch code for a ladder DAC whose bit weights are not powers of two. It runs a digital successive-approximation search. A residue starts at the input code. Each bit, from the top one down, is then tried against that bit's real weight. A bit is kept when the residue can afford its weight, and the weight is then taken off the residue. The code that comes out therefore drives the ladder's actual weights to sum close to the requested value.

The weights are held outside the block in a register file. The block presents the index of the bit it is resolving, and the register file returns that bit's weight in the same cycle. Weights are unsigned fixed point with `FRAC` bits below one input LSB. The residue keeps the same fractional precision, so the compare uses every weight bit. The datapath has one comparator and one subtractor, with no multiplier or divider. One bit is resolved per clock, so a conversion takes `NBITS` cycles. When the ladder is sub-radix-2, the top of the input range cannot be reached, and the upper input codes saturate to all ones.

Top module: `sar_predistort`

## Requirements
- R1: After reset, `busy`, `done`, `cal_code` and `wt_idx` are all 0.
- R2: A `start` sampled while idle begins a conversion. On the next cycle `busy` is 1, `wt_idx` is `NBITS-1` and `cal_code` is 0. `done` rises exactly `NBITS` clock edges after the edge that sampled `start`.
- R3: During a conversion, `wt_idx` steps from `NBITS-1` down to 0, falling by one each cycle, so bits are resolved from the MSB to the LSB.
- R4: For the bit at `wt_idx`, the output bit is set to 1 and `wt_val` is subtracted from the residue when residue >= `wt_val`. Otherwise the bit is 0 and the residue is unchanged. The final `cal_code` equals the greedy decomposition of the input over the weight table.
- R5: The residue starts at `code_in` times 2^`FRAC` (the code shifted up by `FRAC` bits). `wt_val` is compared and subtracted at full fractional precision.
- R6: A `start` that arrives while `busy` is 1 is ignored. The running conversion keeps its sequence, timing and result.
- R7: `done` is high for exactly one cycle per conversion, and `busy` is 0 in that cycle.
- R8: `cal_code` holds its value from `done` until the next accepted `start`.
- R9: With binary weights (weight of bit i = 2^(i+FRAC)), `cal_code` equals `code_in` for every input code.
- R10: The sum of the selected weights never exceeds the target `code_in`·2^`FRAC`. Suppose every weight is at most the sum of all lower weights plus the bit-0 weight, and the target does not exceed the sum of all weights. Then the target minus the selected sum is below the bit-0 weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a conversion when idle |
| code_in | input | NBITS | Ideal binary input code |
| wt_idx | output | $clog2(NBITS) | Index of the bit being resolved, read address into the weight table |
| wt_val | input | NBITS+FRAC | Weight of bit `wt_idx`, in input LSBs with FRAC fraction bits |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when `cal_code` is final |
| cal_code | output | NBITS | Pre-distorted control code for the ladder |

## Verification
The hardest case to reach is the leftover bound of R10. It needs weight sets that are truly sub-radix yet still satisfy the covering condition. The bench therefore builds radix-1.9 tables with small seeded perturbations, and it checks the covering condition itself before it relies on the bound. Every input code is swept against each table. A restart attempt is injected in the middle of a conversion to show that the sequence and result do not change.

// File: rtl/sar_predistort.sv
module sar_predistort #(
  parameter int NBITS = 6,
  parameter int FRAC  = 4,
  localparam int IDX_W = (NBITS > 1) ? $clog2(NBITS) : 1,
  localparam int RW    = NBITS + FRAC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NBITS-1:0] code_in,
  output logic [IDX_W-1:0] wt_idx,
  input  logic [RW-1:0]    wt_val,
  output logic             busy,
  output logic             done,
  output logic [NBITS-1:0] cal_code
);

  localparam logic [IDX_W-1:0] TOP = IDX_W'(NBITS - 1);

  logic [RW-1:0]    res_q;
  logic [IDX_W-1:0] ptr_q;
  logic [NBITS-1:0] code_q;
  logic             busy_q, done_q;
  logic             take;

  assign take     = (res_q >= wt_val);
  assign wt_idx   = ptr_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign cal_code = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      ptr_q  <= '0;
      code_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        busy_q <= 1'b1;
        ptr_q  <= TOP;
        res_q  <= {code_in, {FRAC{1'b0}}};
        code_q <= '0;
      end else if (busy_q) begin
        if (take) begin
          code_q[ptr_q] <= 1'b1;
          res_q         <= res_q - wt_val;
        end
        if (ptr_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          ptr_q <= ptr_q - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sar_predistort_chk.sv
module sar_predistort_chk #(
  parameter int NBITS = 6,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [IDX_W-1:0] wt_idx,
  input logic             busy,
  input logic             done,
  input logic [NBITS-1:0] cal_code
);

  localparam logic [IDX_W-1:0] TOP = IDX_W'(NBITS - 1);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && wt_idx == TOP && cal_code == '0));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wt_idx != '0) |=> (busy && wt_idx == $past(wt_idx) - ONE));

  // R3
  last_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wt_idx == '0) |=> (!busy && done));

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && wt_idx != '0) |=> (wt_idx != TOP || NBITS == 2));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(cal_code));

endmodule

bind sar_predistort sar_predistort_chk #(.NBITS(NBITS), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wt_idx(wt_idx),
  .busy(busy), .done(done), .cal_code(cal_code)
);

// File: tb/test_sar_predistort.sv
module test_sar_predistort;
  localparam int NBITS = 6;
  localparam int FRAC  = 4;
  localparam int IDX_W = $clog2(NBITS);
  localparam int RW    = NBITS + FRAC;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NBITS-1:0] code_in = '0;
  logic [IDX_W-1:0] wt_idx;
  logic [RW-1:0]    wt_val;
  logic busy, done;
  logic [NBITS-1:0] cal_code;
  logic [RW-1:0] wtab [NBITS];

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  assign wt_val = wtab[wt_idx];

  sar_predistort #(.NBITS(NBITS), .FRAC(FRAC)) i_sar_predistort (
    .clk(clk), .rst_n(rst_n), .start(start), .code_in(code_in),
    .wt_idx(wt_idx), .wt_val(wt_val), .busy(busy), .done(done),
    .cal_code(cal_code));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_code(input int code);
    int r = code << FRAC;
    int c = 0;
    for (int i = NBITS - 1; i >= 0; i--)
      if (r >= int'(wtab[i])) begin c |= (1 << i); r -= int'(wtab[i]); end
    return c;
  endfunction

  function automatic int sel_sum(input int c);
    int s = 0;
    for (int i = 0; i < NBITS; i++) if (c[i]) s += int'(wtab[i]);
    return s;
  endfunction

  function automatic bit covering();
    int lower = 0;
    for (int i = 0; i < NBITS; i++) begin
      if (i > 0 && int'(wtab[i]) > lower + int'(wtab[0])) return 0;
      lower += int'(wtab[i]);
    end
    return 1;
  endfunction

  // runs one conversion; optional restart attempt with another code at step 2
  task automatic convert(input int code, input bit poke, output int res);
    int lat = 0;
    int exp = ref_code(code);
    bit idx_ok = 1;
    code_in = NBITS'(code);
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done && lat < 4 * NBITS) begin
      if (int'(wt_idx) != NBITS - 1 - lat || !busy) idx_ok = 0;
      if (poke && lat == 2) begin start = 1; code_in = ~NBITS'(code); end
      else start = 0;
      @(negedge clk);
      lat++;
    end
    start = 0;
    // R2 latency, R6 unchanged under restart attempt
    check(lat == NBITS, poke ? "R6 latency" : "R2 latency", lat, NBITS);
    // R3 index order
    check(idx_ok, "R3 bit order", int'(idx_ok), 1);
    // R4 / R5 greedy result at full fraction
    check(int'(cal_code) == exp, poke ? "R6 result" : "R4 R5 result", int'(cal_code), exp);
    // R7 busy low with done
    check(!busy, "R7 busy low at done", int'(busy), 0);
    res = int'(cal_code);
  endtask

  task automatic sweep(input bit binary);
    int total = 0;
    for (int i = 0; i < NBITS; i++) total += int'(wtab[i]);
    for (int code = 0; code < (1 << NBITS); code++) begin
      int r;
      int tgt = code << FRAC;
      convert(code, 0, r);
      // R10 selected sum never above target
      check(sel_sum(r) <= tgt, "R10 no overshoot", sel_sum(r), tgt);
      if (covering() && tgt <= total)
        check(tgt - sel_sum(r) < int'(wtab[0]), "R10 leftover bound", tgt - sel_sum(r), int'(wtab[0]));
      // R9 binary identity
      if (binary) check(r == code, "R9 identity", r, code);
    end
  endtask

  task automatic load_subradix(input int jitter_pct);
    real k = (2.0 ** NBITS) / ((1.9 ** NBITS - 1.0) / 0.9);
    for (int i = 0; i < NBITS; i++) begin
      real w = k * (1.9 ** i) * (2.0 ** FRAC);
      if (jitter_pct > 0)
        w = w * (1.0 + (real'($urandom_range(2 * jitter_pct, 0)) - jitter_pct) / 100.0);
      wtab[i] = RW'($rtoi(w + 0.5));
    end
  endtask

  initial begin
    int r, held;
    void'($urandom(7));
    for (int i = 0; i < NBITS; i++) wtab[i] = RW'(1 << (i + FRAC));
    #3;
    // R1 reset state
    check(!busy && !done && cal_code == '0 && wt_idx == '0, "R1 reset", int'(cal_code), 0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    sweep(1);
    load_subradix(0);
    sweep(0);
    for (int s = 0; s < 3; s++) begin load_subradix(3); sweep(0); end

    // R6 restart attempt mid-conversion
    load_subradix(0);
    convert(37, 1, r);

    // R7 single cycle pulse, R8 hold until next start
    convert(45, 0, held);
    @(negedge clk);
    check(!done, "R7 done one cycle", int'(done), 0);
    repeat (5) @(negedge clk);
    check(int'(cal_code) == held, "R8 code held", int'(cal_code), held);
    check(!done && !busy, "R8 idle after done", int'(busy), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule